// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This block is a memory-mapped pulse-width modulation timer. One prescaled up-counter sets the period for every output. Each compare channel then turns that common count into one output waveform, using its own duty value and its own output polarity. Software reaches the block over a plain 32-bit register bus: address, write enable, write data, and a registered read-data return.

The period limit (modulo) and each channel's duty value are double-buffered. While the counter is stopped, a written value takes effect at once. While it runs, the written value waits in a holding register and moves into effect at the next counter wrap. A read returns the value in effect, so software can poll a register until it matches the value it wrote. Output polarity and output enable are a two-bit selector per channel. A change to that selector acts immediately.

Top module: `pwmt_top`

## Requirements
- R1: After reset the counter, prescaler, clock mode, modulo and every channel's value and configuration are zero, and all outputs are low. The parameter register at 0x04 returns the channel count in bits [7:0]. The register at 0x08 reads zero.
- R2: The control register at 0x10 holds the prescale select in bits [2:0] and the clock mode in bits [4:3]. With clock mode 01 the counter advances once every 2^prescale clocks. With clock modes 00, 10 and 11 the counter holds its value.
- R3: The counter (0x14) steps from 0 up to the modulo value (0x18) and then returns to 0, so one period is modulo+1 counts. Any write to 0x14 sets the counter to 0.
- R4: While the counter is stopped, a write to the modulo register or to a channel value register (0x24+8n) takes effect at once. A read of that register returns the new value.
- R5: While the counter runs, a write to the modulo or a channel value register is held. Reads keep returning the old value until the counter next wraps to 0, and from then on they return the written value.
- R6: The channel configuration register sits at 0x20+8n, with mode bits B at bit 5 and A at bit 4, and the output selector at bits [3:2]. With B=1, A=0 and selector 10, the output is high while the counter is below the channel value and low otherwise. A value of 0 therefore gives a constant low output, and a value above the modulo gives a constant high output.
- R7: With B=1, A=0 and selector 01, the output is the complement of the R6 waveform.
- R8: Selector 00 or 11, or any mode bits other than B=1, A=0, drives the output low. A selector change reaches the output within two clocks, without waiting for a wrap.
- R9: Bit 7 of a channel configuration register is an event flag. It is set when the counter advances while equal to the channel value. Writing 1 to bit 7 clears the flag, and writing 0 to bit 7 leaves it unchanged.
- R10: Control bit 5 (centre-aligned select) is not implemented and reads 0. Configuration bits 6, 1 and 0 read 0. Other writable fields read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| pwm_o | output | NUM_CH | Registered channel outputs |

## Verification
The sharpest corner is the buffered load. The bench writes the modulo and a channel value just after clearing a running counter and reads back the old value; a design that loads at once would show the new value too early, and one that never loads would keep the old value after the wrap. It also checks that a write to a stopped counter is visible on the next read, which fails on a design that always waits for a wrap. Duty values of 0 and above the modulo must give flat outputs. An off-by-one compare would show a one-count pulse, and the bench catches it by counting high cycles over whole periods. A selector change must act before the next wrap, the event flag must survive a write of 0, and counting must hold in the non-running clock modes.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam logic [7:0] OFS_PARAM   = 8'h04;
  localparam logic [7:0] OFS_GLOBAL  = 8'h08;
  localparam logic [7:0] OFS_CTRL    = 8'h10;
  localparam logic [7:0] OFS_COUNT   = 8'h14;
  localparam logic [7:0] OFS_MODULO  = 8'h18;
  localparam logic [7:0] OFS_CH_BASE = 8'h20;
  localparam int         CH_STRIDE   = 8;

  typedef enum logic [1:0] {
    CLK_OFF      = 2'b00,
    CLK_INTERNAL = 2'b01,
    CLK_RSVD_A   = 2'b10,
    CLK_RSVD_B   = 2'b11
  } clk_mode_e;

  typedef enum logic [1:0] {
    OUT_OFF  = 2'b00,
    OUT_INV  = 2'b01,
    OUT_NORM = 2'b10,
    OUT_RSVD = 2'b11
  } out_sel_e;

  typedef struct packed {
    logic     mode_b;
    logic     mode_a;
    out_sel_e sel;
  } ch_cfg_t;
endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = ~({DIV_W{1'b1}} << ps);
    tick = run && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  assert_no_tick_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> (div_q == '0));
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             clear,
  input  logic             mod_wr,
  input  logic [CNT_W-1:0] mod_wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mod_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, mod_q, mod_buf_q;

  assign wrap_o = tick && (cnt_q >= mod_q);
  assign cnt_o  = cnt_q;
  assign mod_o  = mod_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (tick)   cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_buf_q <= '0;
      mod_q     <= '0;
    end else begin
      if (mod_wr) mod_buf_q <= mod_wdata;
      if (mod_wr && !run) mod_q <= mod_wdata;
      else if (wrap_o)    mod_q <= mod_buf_q;
    end
  end

  assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(cnt_q));
  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !clear && (cnt_q < mod_q)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_stopped_load_R4: assert property (@(posedge clk) disable iff (rst)
    (mod_wr && !run) |=> (mod_q == $past(mod_wdata)));
  assert_mod_held_midperiod_R5: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap_o) |=> $stable(mod_q));
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cfg_wr,
  input  ch_cfg_t          cfg_wdata,
  input  logic             flag_clr,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] val_wdata,
  output ch_cfg_t          cfg_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] val_o,
  output logic             pwm_o
);
  ch_cfg_t          cfg_q;
  logic [CNT_W-1:0] val_q, val_buf_q;
  logic             flag_q, pwm_q, below, pwm_mode, drive, match;

  always_comb begin
    below    = (cnt < val_q);
    pwm_mode = cfg_q.mode_b && !cfg_q.mode_a;
    match    = tick && (cnt == val_q);
    unique case (cfg_q.sel)
      OUT_NORM: drive = pwm_mode && below;
      OUT_INV:  drive = pwm_mode && !below;
      default:  drive = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      val_q     <= '0;
      val_buf_q <= '0;
      flag_q    <= 1'b0;
      pwm_q     <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_wdata;
      if (val_wr) val_buf_q <= val_wdata;
      if (val_wr && !run) val_q <= val_wdata;
      else if (wrap)      val_q <= val_buf_q;
      if (match)         flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      pwm_q <= drive;
    end
  end

  assign cfg_o  = cfg_q;
  assign flag_o = flag_q;
  assign val_o  = val_q;
  assign pwm_o  = pwm_q;

  assert_zero_duty_low_R6: assert property (@(posedge clk) disable iff (rst)
    (pwm_mode && cfg_q.sel == OUT_NORM && val_q == '0) |=> !pwm_q);
  assert_off_select_low_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.sel == OUT_OFF || cfg_q.sel == OUT_RSVD || !pwm_mode) |=> !pwm_q);
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !match) |=> !flag_q);
  assert_val_held_midperiod_R5: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> $stable(val_q));
endmodule

// File: rtl/pwmt_top.sv
module pwmt_top
  import pwmt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam logic [ADDR_W-1:0] A_PARAM  = ADDR_W'(OFS_PARAM);
  localparam logic [ADDR_W-1:0] A_GLOBAL = ADDR_W'(OFS_GLOBAL);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_MODULO = ADDR_W'(OFS_MODULO);

  logic [PS_W-1:0]  ps_q;
  clk_mode_e        cmode_q;
  logic             run, tick, wrap;
  logic [CNT_W-1:0] cnt, mod_val;
  logic [31:0]      rd_next;
  logic             unused_wdata;

  ch_cfg_t          ch_cfg  [NUM_CH];
  logic             ch_flag [NUM_CH];
  logic [CNT_W-1:0] ch_val  [NUM_CH];

  assign run          = (cmode_q == CLK_INTERNAL);
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q    <= '0;
      cmode_q <= CLK_OFF;
    end else if (bus_we && bus_addr == A_CTRL) begin
      ps_q    <= bus_wdata[PS_W-1:0];
      cmode_q <= clk_mode_e'(bus_wdata[4:3]);
    end
  end

  pwmt_prescaler #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst(rst), .run(run), .ps(ps_q), .tick(tick)
  );

  pwmt_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .run(run), .tick(tick),
    .clear(bus_we && bus_addr == A_COUNT),
    .mod_wr(bus_we && bus_addr == A_MODULO),
    .mod_wdata(bus_wdata[CNT_W-1:0]),
    .cnt_o(cnt), .mod_o(mod_val), .wrap_o(wrap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(int'(OFS_CH_BASE) + CH_STRIDE * g);
    localparam logic [ADDR_W-1:0] A_VAL = ADDR_W'(int'(OFS_CH_BASE) + CH_STRIDE * g + 4);
    logic cfg_hit;
    assign cfg_hit = bus_we && bus_addr == A_CFG;

    pwmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .run(run), .tick(tick), .wrap(wrap), .cnt(cnt),
      .cfg_wr(cfg_hit),
      .cfg_wdata(ch_cfg_t'(bus_wdata[5:2])),
      .flag_clr(cfg_hit && bus_wdata[7]),
      .val_wr(bus_we && bus_addr == A_VAL),
      .val_wdata(bus_wdata[CNT_W-1:0]),
      .cfg_o(ch_cfg[g]), .flag_o(ch_flag[g]), .val_o(ch_val[g]),
      .pwm_o(pwm_o[g])
    );
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == A_PARAM)  rd_next = 32'(NUM_CH);
    if (bus_addr == A_GLOBAL) rd_next = '0;
    if (bus_addr == A_CTRL)   rd_next = {27'd0, cmode_q, 3'(ps_q)};
    if (bus_addr == A_COUNT)  rd_next = 32'(cnt);
    if (bus_addr == A_MODULO) rd_next = 32'(mod_val);
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(int'(OFS_CH_BASE) + CH_STRIDE * i))
        rd_next = {24'd0, ch_flag[i], 1'b0, ch_cfg[i], 2'b00};
      if (bus_addr == ADDR_W'(int'(OFS_CH_BASE) + CH_STRIDE * i + 4))
        rd_next = 32'(ch_val[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assert_outputs_low_after_reset_R1: assert property (@(posedge clk)
    rst |=> (pwm_o == '0));
  assert_param_readback_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_PARAM) |=> (bus_rdata[7:0] == 8'(NUM_CH)));
endmodule

// File: tb/pwmt_top_tb_top.sv
`timescale 1ns/1ps
module pwmt_top_tb_top;
  localparam int NUM_CH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NUM_CH-1:0] pwm_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pwmt_top #(.NUM_CH(NUM_CH), .CNT_W(16), .PS_W(3), .ADDR_W(8)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic count_high(input int cycles, output int hi [NUM_CH]);
    for (int c = 0; c < NUM_CH; c++) hi[c] = 0;
    repeat (cycles) begin
      @(negedge clk);
      for (int c = 0; c < NUM_CH; c++) hi[c] += int'(pwm_o[c]);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    check(pwm_o == '0, "R1 outputs", pwm_o, 0);
    rd(8'h04, d); check(d[7:0] == NUM_CH, "R1 param", d, NUM_CH);
    rd(8'h08, d); check(d == 0, "R1 global", d, 0);
    rd(8'h10, d); check(d == 0, "R1 ctrl", d, 0);
    rd(8'h14, d); check(d == 0, "R1 count", d, 0);
    rd(8'h18, d); check(d == 0, "R1 modulo", d, 0);
    rd(8'h24, d); check(d == 0, "R1 ch0 value", d, 0);
  endtask

  task automatic t_prescale();
    logic [31:0] a, b;
    do_reset();
    wr(8'h18, 32'd1000);
    wr(8'h10, 32'h0A);           // run, prescale 2
    wr(8'h14, 0);
    @(negedge clk); bus_addr = 8'h14;
    repeat (2) @(negedge clk); a = bus_rdata;
    repeat (80) @(negedge clk); b = bus_rdata;
    check(b - a == 20, "R2 prescale 4", b - a, 20);
    wr(8'h10, 32'h00);           // mode 00 stops
    rd(8'h14, a); repeat (50) @(negedge clk); rd(8'h14, b);
    check(a == b, "R2 mode00 holds", b, a);
    wr(8'h10, 32'h10);           // mode 10 also holds
    rd(8'h14, a); repeat (50) @(negedge clk); rd(8'h14, b);
    check(a == b, "R2 mode10 holds", b, a);
  endtask

  task automatic t_wrap();
    logic [31:0] d, prev;
    int mx;
    bit seq_ok;
    do_reset();
    wr(8'h18, 32'd9);
    wr(8'h10, 32'h08);
    @(negedge clk); bus_addr = 8'h14;
    @(negedge clk); prev = bus_rdata;
    mx = 0; seq_ok = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); d = bus_rdata;
      if (d != (prev + 1) % 10) seq_ok = 1'b0;
      if (int'(d) > mx) mx = int'(d);
      prev = d;
    end
    check(seq_ok, "R3 step and wrap", prev, (prev + 0));
    check(mx == 9, "R3 top count", mx, 9);
    wr(8'h10, 32'h00);
    wr(8'h14, 32'hFF);
    rd(8'h14, d);
    check(d == 0, "R3 counter write clears", d, 0);
  endtask

  task automatic t_buffer();
    logic [31:0] d;
    do_reset();
    wr(8'h18, 32'd123); rd(8'h18, d);
    check(d == 123, "R4 stopped modulo", d, 123);
    wr(8'h34, 32'd77);  rd(8'h34, d);
    check(d == 77, "R4 stopped value", d, 77);
    wr(8'h18, 32'd99);
    wr(8'h2C, 32'd10);
    wr(8'h10, 32'h08);
    wr(8'h14, 0);
    wr(8'h18, 32'd49);
    wr(8'h2C, 32'd30);
    rd(8'h18, d); check(d == 99, "R5 running modulo held", d, 99);
    rd(8'h2C, d); check(d == 10, "R5 running value held", d, 10);
    repeat (120) @(negedge clk);
    rd(8'h18, d); check(d == 49, "R5 modulo loaded at wrap", d, 49);
    rd(8'h2C, d); check(d == 30, "R5 value loaded at wrap", d, 30);
  endtask

  task automatic t_duty();
    int hi [NUM_CH];
    do_reset();
    wr(8'h18, 32'd19);
    wr(8'h24, 32'd7);  wr(8'h20, 32'h28);
    wr(8'h2C, 32'd0);  wr(8'h28, 32'h28);
    wr(8'h34, 32'd25); wr(8'h30, 32'h28);
    wr(8'h3C, 32'd7);  wr(8'h38, 32'h24);
    wr(8'h10, 32'h08);
    repeat (50) @(negedge clk);
    count_high(200, hi);
    check(hi[0] == 70,  "R6 normal duty 7/20", hi[0], 70);
    check(hi[1] == 0,   "R6 duty 0 low", hi[1], 0);
    check(hi[2] == 200, "R6 duty above modulo high", hi[2], 200);
    check(hi[3] == 130, "R7 inverted duty", hi[3], 130);
  endtask

  task automatic t_select();
    int hi [NUM_CH];
    do_reset();
    wr(8'h18, 32'd19);
    wr(8'h24, 32'd7);  wr(8'h20, 32'h20);   // selector 00
    wr(8'h2C, 32'd7);  wr(8'h28, 32'h2C);   // selector 11
    wr(8'h34, 32'd7);  wr(8'h30, 32'h38);   // mode A set
    wr(8'h10, 32'h08);
    repeat (30) @(negedge clk);
    count_high(200, hi);
    check(hi[0] == 0, "R8 selector 00 low", hi[0], 0);
    check(hi[1] == 0, "R8 selector 11 low", hi[1], 0);
    check(hi[2] == 0, "R8 wrong mode low", hi[2], 0);
    wr(8'h18, 32'd999);
    wr(8'h14, 0);
    wr(8'h24, 32'd1000);
    wr(8'h20, 32'h28);
    repeat (20) @(negedge clk);
    check(pwm_o[0] == 1'b1, "R8 constant high before switch", pwm_o[0], 1);
    wr(8'h20, 32'h24);
    repeat (2) @(negedge clk);
    check(pwm_o[0] == 1'b0, "R8 selector acts before wrap", pwm_o[0], 0);
  endtask

  task automatic t_flag_fields();
    logic [31:0] d;
    do_reset();
    wr(8'h18, 32'd19);
    wr(8'h24, 32'd5); wr(8'h20, 32'h28);
    wr(8'h10, 32'h08);
    repeat (50) @(negedge clk);
    wr(8'h10, 32'h00);
    rd(8'h20, d); check(d[7] == 1'b1, "R9 flag set on match", d[7], 1);
    wr(8'h20, 32'h28);
    rd(8'h20, d); check(d[7] == 1'b1, "R9 write 0 keeps flag", d[7], 1);
    wr(8'h20, 32'hA8);
    rd(8'h20, d); check(d[7] == 1'b0, "R9 write 1 clears flag", d[7], 0);
    wr(8'h10, 32'h3F);
    rd(8'h10, d); check(d == 32'h1F, "R10 ctrl readback", d, 32'h1F);
    wr(8'h28, 32'hFF);
    rd(8'h28, d); check(d == 32'h3C, "R10 config readback", d, 32'h3C);
  endtask

  initial begin
    t_reset();
    t_prescale();
    t_wrap();
    t_buffer();
    t_duty();
    t_select();
    t_flag_fields();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule